// File: doc/BRIEF.md
# Nearest-Not-Above Parent Frequency Selector

This block chooses which of several parent clocks a clock mux should follow when software asks for a particular rate. A request carries a target frequency, a table of candidate parent frequencies (one per mux input) with a per-slot "present" flag, and the index of the parent the mux uses today. The block captures the request, then looks at one candidate slot per clock. It returns the index and frequency of the winning slot. There is always a winner; an exact match is never required.

The running best is seeded with the current parent, so a candidate has to be strictly better to take over. That keeps the mux where it is when nothing better exists. "Better" means this: the highest frequency that does not exceed the target. If every candidate is above the target, the lowest one wins instead.

Both ends of the block are valid/ready streams. A request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high. `req_ready_o` is high only while the block is idle. A result sits on the outputs with `res_valid_o` high until an edge where `res_ready_i` is high. While the result waits, the block accepts no new request. Neither side may withdraw or change a request or result it has offered until the handshake completes.

Top module: `freq_parent_picker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `res_valid_o` is 0.
- R2: A request is accepted on an edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 from that edge until the edge on which the result is handed over.
- R3: While `res_valid_o` is 1 and `res_ready_i` is 0, `res_valid_o`, `res_idx_o` and `res_freq_o` hold steady. On the edge where `res_ready_i` is 1, `res_valid_o` drops and `req_ready_o` returns to 1.
- R4: One slot is examined per clock, slot 0 first. `res_valid_o` rises exactly NUM_SLOTS clock edges after the accepting edge.
- R5: The running best starts as slot `cur_idx_i` with its frequency. If no slot displaces it, the result is that index and frequency.
- R6: If any examined candidate, or the seed, is at or below the target, the result is the highest such frequency, and an exact match wins.
- R7: If the seed and every present candidate are above the target, the result is the lowest of them.
- R8: A candidate whose frequency equals the running best never displaces it, so the earlier holder (the seed, then lower slot numbers) wins ties.
- R9: A slot whose bit in `cand_valid_i` is 0 (bit i belongs to slot i, whose frequency is `cand_freq_i[i*FREQ_W +: FREQ_W]`) is never chosen by the scan, even when it matches the target exactly.
- R10: Target, table and current index are captured on the accepting edge. Changes to those inputs during the scan do not change the result.
- R11: The seed is taken from slot `cur_idx_i` whatever that slot's present flag is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request can be taken |
| target_i | input | FREQ_W | Target frequency |
| cur_idx_i | input | IDX_W | Index of the parent in use now (below NUM_SLOTS) |
| cand_valid_i | input | NUM_SLOTS | Per-slot present flag |
| cand_freq_i | input | NUM_SLOTS*FREQ_W | Candidate frequencies, slot i at bits i*FREQ_W |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Consumer takes the result |
| res_idx_o | output | IDX_W | Chosen slot index |
| res_freq_o | output | FREQ_W | Frequency of the chosen slot |

## Verification
The stimulus goes after the cases where the two-sided update rule can go wrong:
- **Seed above, lower candidate below.** A seed above the target must be beaten by a candidate below it. A design that tested only "higher but not above" would stay stuck on the seed.
- **Candidate below arrives first.** Once a candidate below the target has been found, a later, lower one must not take over. A design that always moved downward would end on the smallest value.
- **Ties.** Ties on frequency must keep the earlier holder. A non-strict comparison would switch parents for no gain, and the bench would see the wrong index.
- **Empty slot matching exactly.** An empty slot carrying an exact match must be skipped.
- **Empty current slot.** An empty current slot must still seed the search.
- **Inputs changed during the scan.** A design that read the live inputs instead of the captured ones would report the new values.
- **Stalled result.** The result is held under a stalled `res_ready_i`, and the result latency is counted cycle by cycle.

// File: rtl/freq_pick_pkg.sv
package freq_pick_pkg;

  typedef enum logic [1:0] {
    PICK_IDLE = 2'd0,
    PICK_SCAN = 2'd1,
    PICK_DONE = 2'd2
  } pick_state_e;

  function automatic int idx_width(input int slots);
    return (slots > 1) ? $clog2(slots) : 1;
  endfunction

endpackage

// File: rtl/freq_best_rule.sv
// Decides whether one candidate displaces the running best.
module freq_best_rule #(
  parameter int FREQ_W = 32
) (
  input  logic [FREQ_W-1:0] target,
  input  logic [FREQ_W-1:0] best_freq,
  input  logic [FREQ_W-1:0] cand_freq,
  input  logic              cand_ok,
  output logic              take
);

  logic best_above;
  logic move_down;
  logic move_up;

  always_comb begin
    best_above = best_freq > target;
    // Best overshoots: any strictly lower candidate is an improvement.
    move_down  = best_above && (cand_freq < best_freq);
    // Otherwise climb toward the target without passing it.
    move_up    = (cand_freq > best_freq) && (cand_freq <= target);
    take       = cand_ok && (move_down || move_up);
  end

endmodule

// File: rtl/freq_cand_store.sv
// Snapshot of the candidate table, read one slot at a time.
module freq_cand_store #(
  parameter int NUM_SLOTS = 8,
  parameter int FREQ_W    = 32,
  parameter int IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load,
  input  logic [NUM_SLOTS*FREQ_W-1:0] cand_freq_i,
  input  logic [NUM_SLOTS-1:0]        cand_valid_i,
  input  logic [IDX_W-1:0]            rd_idx,
  output logic [FREQ_W-1:0]           rd_freq,
  output logic                        rd_ok
);

  logic [FREQ_W-1:0] freq_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] ok_q;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        freq_q[g] <= '0;
        ok_q[g]   <= 1'b0;
      end else if (load) begin
        freq_q[g] <= cand_freq_i[g*FREQ_W +: FREQ_W];
        ok_q[g]   <= cand_valid_i[g];
      end
    end
  end

  always_comb begin
    rd_freq = '0;
    rd_ok   = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_freq = freq_q[i];
        rd_ok   = ok_q[i];
      end
    end
  end

endmodule

// File: rtl/freq_scan_seq.sv
// Handshake and slot sequencing.
module freq_scan_seq
  import freq_pick_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             res_ready,
  output logic             req_ready,
  output logic             res_valid,
  output logic             accept,
  output logic             scan_en,
  output logic [IDX_W-1:0] slot_idx
);

  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(NUM_SLOTS - 1);
  localparam int LAT_W = $clog2(NUM_SLOTS + 2) + 1;

  pick_state_e state_q;
  logic [IDX_W-1:0] cnt_q;

  assign req_ready = (state_q == PICK_IDLE);
  assign res_valid = (state_q == PICK_DONE);
  assign scan_en   = (state_q == PICK_SCAN);
  assign accept    = req_valid && req_ready;
  assign slot_idx  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PICK_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        PICK_IDLE: if (accept) begin
          state_q <= PICK_SCAN;
          cnt_q   <= '0;
        end
        PICK_SCAN: begin
          if (cnt_q == LAST_SLOT) begin
            state_q <= PICK_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PICK_DONE: if (res_ready) state_q <= PICK_IDLE;
        default:   state_q <= PICK_IDLE;
      endcase
    end
  end

  // Checker state: scan cycles counted since the last accepted request.
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_q <= '0;
    else if (accept)  lat_q <= '0;
    else if (scan_en) lat_q <= lat_q + 1'b1;
  end

  // R4: result appears after exactly NUM_SLOTS scan cycles
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> (lat_q == LAT_W'(NUM_SLOTS)));

  // R2: an accepted request closes the request port on the next cycle
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R3: handing over the result reopens the request port
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (req_ready && !res_valid));

endmodule

// File: rtl/freq_parent_picker.sv
// Picks the parent slot nearest to, and not above, a target frequency.
module freq_parent_picker
  import freq_pick_pkg::*;
#(
  parameter  int NUM_SLOTS = 8,
  parameter  int FREQ_W    = 32,
  localparam int IDX_W     = idx_width(NUM_SLOTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [FREQ_W-1:0]           target_i,
  input  logic [IDX_W-1:0]            cur_idx_i,
  input  logic [NUM_SLOTS-1:0]        cand_valid_i,
  input  logic [NUM_SLOTS*FREQ_W-1:0] cand_freq_i,
  output logic                        res_valid_o,
  input  logic                        res_ready_i,
  output logic [IDX_W-1:0]            res_idx_o,
  output logic [FREQ_W-1:0]           res_freq_o
);

  logic              accept;
  logic              scan_en;
  logic [IDX_W-1:0]  slot_idx;
  logic [FREQ_W-1:0] rd_freq;
  logic              rd_ok;
  logic              take;
  logic [FREQ_W-1:0] seed_freq;

  logic [FREQ_W-1:0] tgt_q;
  logic [FREQ_W-1:0] best_freq_q;
  logic [IDX_W-1:0]  best_idx_q;

  freq_scan_seq #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid_i),
    .res_ready (res_ready_i),
    .req_ready (req_ready_o),
    .res_valid (res_valid_o),
    .accept    (accept),
    .scan_en   (scan_en),
    .slot_idx  (slot_idx)
  );

  freq_cand_store #(.NUM_SLOTS(NUM_SLOTS), .FREQ_W(FREQ_W), .IDX_W(IDX_W)) store_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (accept),
    .cand_freq_i  (cand_freq_i),
    .cand_valid_i (cand_valid_i),
    .rd_idx       (slot_idx),
    .rd_freq      (rd_freq),
    .rd_ok        (rd_ok)
  );

  freq_best_rule #(.FREQ_W(FREQ_W)) rule_i (
    .target    (tgt_q),
    .best_freq (best_freq_q),
    .cand_freq (rd_freq),
    .cand_ok   (rd_ok),
    .take      (take)
  );

  // Seed comes straight from the incoming table; the present flag is not consulted.
  always_comb begin
    seed_freq = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (cur_idx_i == IDX_W'(i)) seed_freq = cand_freq_i[i*FREQ_W +: FREQ_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q       <= '0;
      best_freq_q <= '0;
      best_idx_q  <= '0;
    end else if (accept) begin
      tgt_q       <= target_i;
      best_freq_q <= seed_freq;
      best_idx_q  <= cur_idx_i;
    end else if (scan_en && take) begin
      best_freq_q <= rd_freq;
      best_idx_q  <= slot_idx;
    end
  end

  assign res_idx_o  = best_idx_q;
  assign res_freq_o = best_freq_q;

  // R3: a stalled result stays put
  a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && !res_ready_i) |=>
      (res_valid_o && $stable(res_idx_o) && $stable(res_freq_o)));

  // R6: once at or below the target, the best never climbs past it
  a_r6_stay_below: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && best_freq_q <= tgt_q) |=> (best_freq_q <= tgt_q));

  // R7: while above the target, the best only moves downward
  a_r7_descend: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && best_freq_q > tgt_q) |=> (best_freq_q <= $past(best_freq_q)));

  // R9: an empty slot leaves the running best untouched
  a_r9_skip_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !rd_ok) |=> ($stable(best_idx_q) && $stable(best_freq_q)));

endmodule

// File: tb/freq_parent_picker_tb_top.sv
`timescale 1ns/1ps
module freq_parent_picker_tb_top;

  localparam int NS = 8;
  localparam int FW = 32;
  localparam int IW = 3;
  localparam int NV = 8;

  typedef struct packed {
    logic [15:0]         tgt;   // MHz
    logic [2:0]          cur;
    logic [7:0]          mask;
    logic [0:7][15:0]    f;     // MHz, slot 0 first
    logic [2:0]          exp_idx;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    // R6: seed 500 above 300, best not above is 250 in slot 2
    '{16'd300, 3'd0, 8'hFF, '{16'd500,16'd100,16'd250,16'd400,16'd800,16'd200,16'd700,16'd600}, 3'd2},
    // R6: exact match 400 in slot 3
    '{16'd400, 3'd1, 8'hFF, '{16'd500,16'd100,16'd250,16'd400,16'd800,16'd200,16'd700,16'd600}, 3'd3},
    // R7: everything above 50, lowest is 100 in slot 1
    '{16'd50,  3'd4, 8'hFF, '{16'd500,16'd100,16'd250,16'd400,16'd800,16'd200,16'd700,16'd600}, 3'd1},
    // R9: slot 2 empty, so 200 in slot 5 wins
    '{16'd300, 3'd0, 8'hFB, '{16'd500,16'd100,16'd250,16'd400,16'd800,16'd200,16'd700,16'd600}, 3'd5},
    // R8: seed slot 1 ties with slot 0, seed kept
    '{16'd300, 3'd1, 8'hFF, '{16'd300,16'd300,16'd100,16'd900,16'd900,16'd900,16'd900,16'd900}, 3'd1},
    // R5: only the seed slot is present, nothing displaces it
    '{16'd10,  3'd3, 8'h08, '{16'd300,16'd300,16'd100,16'd900,16'd900,16'd900,16'd900,16'd900}, 3'd3},
    // R11: seed slot empty and no slot present, seed still returned
    '{16'd1000,3'd2, 8'h00, '{16'd500,16'd100,16'd250,16'd400,16'd800,16'd200,16'd700,16'd600}, 3'd2},
    // R8: two 200 candidates, the lower slot keeps it
    '{16'd300, 3'd0, 8'hFF, '{16'd900,16'd200,16'd200,16'd50,16'd900,16'd900,16'd900,16'd900}, 3'd1}
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [FW-1:0]    target = '0;
  logic [IW-1:0]    cur_idx = '0;
  logic [NS-1:0]    cand_valid = '0;
  logic [NS*FW-1:0] cand_freq = '0;
  logic             res_valid;
  logic             res_ready = 1'b0;
  logic [IW-1:0]    res_idx;
  logic [FW-1:0]    res_freq;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  freq_parent_picker #(.NUM_SLOTS(NS), .FREQ_W(FW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid),
    .req_ready_o  (req_ready),
    .target_i     (target),
    .cur_idx_i    (cur_idx),
    .cand_valid_i (cand_valid),
    .cand_freq_i  (cand_freq),
    .res_valid_o  (res_valid),
    .res_ready_i  (res_ready),
    .res_idx_o    (res_idx),
    .res_freq_o   (res_freq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hz(input logic [15:0] mhz);
    return 32'(mhz) * 32'd1000000;
  endfunction

  task automatic drive_vec(input vec_t v);
    target     = hz(v.tgt);
    cur_idx    = v.cur;
    cand_valid = v.mask;
    for (int s = 0; s < NS; s++) cand_freq[s*FW +: FW] = hz(v.f[s]);
  endtask

  // Offers a request, waits for the result; returns scan latency in cycles.
  task automatic launch(input vec_t v, output int lat);
    @(negedge clk);
    drive_vec(v);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic take_result();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  initial begin
    int lat;
    vec_t alt;
    repeat (3) @(negedge clk);
    chk("R1 req_ready after reset", 32'(req_ready), 32'd1);
    chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready idle", 32'(req_ready), 32'd1);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      launch(VECS[v], lat);
      chk("R4 latency", 32'(lat), 32'(NS));
      chk("R5-R11 vector index", 32'(res_idx), 32'(VECS[v].exp_idx));
      chk("R5-R11 vector freq", res_freq, hz(VECS[v].f[VECS[v].exp_idx]));
      take_result();
      chk("R3 valid drops after handover", 32'(res_valid), 32'd0);
      chk("R3 ready back after handover", 32'(req_ready), 32'd1);
    end

    // R2: port closed during scan; R10: live input changes ignored
    @(negedge clk);
    drive_vec(VECS[0]);
    req_valid = 1'b1;
    @(negedge clk);
    chk("R2 req_ready low after accept", 32'(req_ready), 32'd0);
    alt = VECS[6];
    alt.tgt = 16'd50;
    alt.mask = 8'h00;
    drive_vec(alt);
    cur_idx = 3'd7;
    repeat (3) @(negedge clk);
    chk("R2 req_ready low while scanning", 32'(req_ready), 32'd0);
    req_valid = 1'b0;
    lat = 0;
    while (!res_valid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    chk("R10 index from captured request", 32'(res_idx), 32'd2);
    chk("R10 freq from captured request", res_freq, hz(16'd250));

    // R3: stall the consumer
    repeat (3) @(negedge clk);
    chk("R3 valid held under stall", 32'(res_valid), 32'd1);
    chk("R3 index held under stall", 32'(res_idx), 32'd2);
    chk("R3 freq held under stall", res_freq, hz(16'd250));
    chk("R2 req_ready low while result waits", 32'(req_ready), 32'd0);
    take_result();
    chk("R3 valid cleared after stall", 32'(res_valid), 32'd0);

    // R9: the only exact match sits in an empty slot
    alt = VECS[0];
    alt.mask = 8'hF7;
    alt.tgt = 16'd400;
    launch(alt, lat);
    chk("R9 empty exact match skipped", 32'(res_idx), 32'd2);
    take_result();

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule